// File: doc/BRIEF.md
# Packed Saturating Lane Arithmetic Unit

This unit treats each of its two 64-bit inputs as four unrelated 16-bit words and applies one of eight element-wise operations to every word at once. Sums and differences can wrap modulo 2^16, clamp as unsigned numbers, or clamp as two's-complement numbers. Two further operations are built from those primitives inside each word: the unsigned maximum, and the unsigned absolute difference.

A caller presents both operands and a 3-bit operation code together with a valid strobe. The packed result appears one clock later on a registered output with its own valid flag. Word k of every vector occupies bits [16k+15:16k]. The lane width and lane count are parameters.

Top module: `psimd_sat_alu`

## Requirements
- R1: When `in_valid` is high at a rising clock edge, `out_valid` is high and `result` holds the answer for that edge's inputs after the same edge, so both are visible one cycle after the inputs were presented.
- R2: While `rst_n` is low, `out_valid` and `result` are both 0.
- R3: Each 16-bit word (word k at bits [16k+15:16k]) is computed only from the same word of both operands, so no carry or borrow crosses a word boundary. For example, 0xFFFF + 1 in word 0 gives 0 there and leaves word 1 at 0.
- R4: Code 0 gives a + b modulo 2^16 per word. Code 1 gives a − b modulo 2^16 per word.
- R5: Code 2 gives the unsigned sum per word, clamped to 0xFFFF when it exceeds that value.
- R6: Code 3 gives the unsigned difference a − b per word, clamped to 0 when b > a. For example, words (58, 14, 12, 77) minus (22, 192, 118, 36) give (36, 0, 0, 41).
- R7: Code 4 gives the two's-complement sum per word, clamped to 0x7FFF above and to 0x8000 below.
- R8: Code 5 gives the two's-complement difference a − b per word, with the same clamps as R7.
- R9: Code 6 gives the unsigned maximum of a and b per word. This is formed as the clamped difference of R6 plus b. For example, (58, 14, 12, 77) and (22, 192, 118, 36) give (58, 192, 118, 77).
- R10: Code 7 gives the unsigned |a − b| per word. This is formed as the clamped difference a − b plus the clamped difference b − a.
- R11: A rising edge at which `in_valid` is low clears `out_valid` and leaves `result` unchanged, whatever the operands and code are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | The operands and code are to be processed at this edge |
| op | input | 3 | Operation code, 0 to 7, as listed in R4 to R10 |
| src_a | input | 64 | First packed operand, four 16-bit words |
| src_b | input | 64 | Second packed operand, four 16-bit words |
| out_valid | output | 1 | `result` holds a new answer |
| result | output | 64 | Registered packed result |

## Verification
Every arithmetic result is due exactly one rising edge after it is presented. The bench therefore drives inputs on a falling edge and compares `result` and `out_valid` on the next falling edge, half a period after the capturing edge. Back-to-back vectors follow the same one-cycle rhythm. For the idle case of R11, the bench changes the operands with `in_valid` low and checks at the next falling edge that `out_valid` has dropped and `result` still carries the previous answer.

// File: rtl/psimd_pkg.sv
package psimd_pkg;

   typedef enum logic [2:0] {
      OP_ADD_WRAP = 3'd0,
      OP_SUB_WRAP = 3'd1,
      OP_ADD_US   = 3'd2,
      OP_SUB_US   = 3'd3,
      OP_ADD_SS   = 3'd4,
      OP_SUB_SS   = 3'd5,
      OP_MAX_U    = 3'd6,
      OP_ABSD_U   = 3'd7
   } psimd_op_e;

endpackage

// File: rtl/psimd_addsub.sv
// One W-bit adder or subtractor (chosen by SUBTRACT) that exposes the wrapped
// result, the unsigned carry/borrow, and the signed-saturated result.
module psimd_addsub #(
   parameter int W        = 16,
   parameter bit SUBTRACT = 1'b0
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] wrap,
   output logic         carry,
   output logic [W-1:0] ssat
);
   localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

   logic [W:0] uwide;
   logic [W:0] swide;

   generate
      if (SUBTRACT) begin : g_sub
         always_comb begin
            uwide = {1'b0, x} - {1'b0, y};
            swide = {x[W-1], x} - {y[W-1], y};
         end
      end else begin : g_add
         always_comb begin
            uwide = {1'b0, x} + {1'b0, y};
            swide = {x[W-1], x} + {y[W-1], y};
         end
      end
   endgenerate

   assign wrap  = uwide[W-1:0];
   assign carry = uwide[W];
   assign ssat  = (swide[W] != swide[W-1]) ? (swide[W] ? SMIN : SMAX)
                                           : swide[W-1:0];
endmodule

// File: rtl/psimd_lane.sv
// One lane: every operation is derived from one adder and one subtractor.
module psimd_lane
   import psimd_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [2:0]   op,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);
   localparam logic [W-1:0] UMAX = '1;

   logic [W-1:0] sum_wrap, sum_ss, dif_wrap, dif_ss;
   logic         sum_cy, dif_bw;
   logic [W-1:0] sum_us, dif_us, rdif_us;

   psimd_addsub #(.W(W), .SUBTRACT(1'b0)) u_add (
      .x(a), .y(b), .wrap(sum_wrap), .carry(sum_cy), .ssat(sum_ss));

   psimd_addsub #(.W(W), .SUBTRACT(1'b1)) u_sub (
      .x(a), .y(b), .wrap(dif_wrap), .carry(dif_bw), .ssat(dif_ss));

   assign sum_us  = sum_cy ? UMAX : sum_wrap;
   assign dif_us  = dif_bw ? '0 : dif_wrap;
   // b - a is the negation of the wrapped a - b; it is only positive on borrow
   assign rdif_us = dif_bw ? (~dif_wrap + 1'b1) : '0;

   always_comb begin
      unique case (psimd_op_e'(op))
         OP_ADD_WRAP: y = sum_wrap;
         OP_SUB_WRAP: y = dif_wrap;
         OP_ADD_US:   y = sum_us;
         OP_SUB_US:   y = dif_us;
         OP_ADD_SS:   y = sum_ss;
         OP_SUB_SS:   y = dif_ss;
         OP_MAX_U:    y = dif_us + b;
         OP_ABSD_U:   y = dif_us + rdif_us;
         default:     y = '0;
      endcase
   end
endmodule

// File: rtl/psimd_sat_alu.sv
module psimd_sat_alu #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   input  logic [2:0]                op,
   input  logic [LANES*LANE_W-1:0]   src_a,
   input  logic [LANES*LANE_W-1:0]   src_b,
   output logic                      out_valid,
   output logic [LANES*LANE_W-1:0]   result
);
   localparam int VEC_W = LANES * LANE_W;

   generate
      if (LANE_W < 2) begin : g_bad_width
         $error("psimd_sat_alu: LANE_W must be at least 2");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("psimd_sat_alu: LANES must be at least 1");
      end
   endgenerate

   logic [VEC_W-1:0] lane_y;

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane
         psimd_lane #(.W(LANE_W)) u_lane (
            .op(op),
            .a (src_a[l*LANE_W +: LANE_W]),
            .b (src_b[l*LANE_W +: LANE_W]),
            .y (lane_y[l*LANE_W +: LANE_W]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= lane_y;
      end
   end
endmodule

// File: rtl/psimd_sat_alu_chk.sv
module psimd_sat_alu_chk #(
   parameter int LANE_W = 16,
   parameter int LANES  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    in_valid,
   input logic [2:0]              op,
   input logic [LANES*LANE_W-1:0] src_a,
   input logic [LANES*LANE_W-1:0] src_b,
   input logic                    out_valid,
   input logic [LANES*LANE_W-1:0] result
);
   localparam logic [LANE_W-1:0] UMAX = '1;

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   a_r11_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(result)));

   generate
      for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
         // R6: clamped to zero when b exceeds a
         a_r6_floor_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == 3'd3 && src_a[l*LANE_W +: LANE_W] < src_b[l*LANE_W +: LANE_W])
            |=> (result[l*LANE_W +: LANE_W] == '0));

         // R5: clamped to all ones when the sum overflows
         a_r5_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == 3'd2 &&
             ({1'b0, src_a[l*LANE_W +: LANE_W]} + {1'b0, src_b[l*LANE_W +: LANE_W]} > {1'b0, UMAX}))
            |=> (result[l*LANE_W +: LANE_W] == UMAX));

         // R9: max is one of the operands and no smaller than either
         a_r9_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == 3'd6) |=>
            ((result[l*LANE_W +: LANE_W] >= $past(src_a[l*LANE_W +: LANE_W])) &&
             (result[l*LANE_W +: LANE_W] >= $past(src_b[l*LANE_W +: LANE_W])) &&
             ((result[l*LANE_W +: LANE_W] == $past(src_a[l*LANE_W +: LANE_W])) ||
              (result[l*LANE_W +: LANE_W] == $past(src_b[l*LANE_W +: LANE_W])))));

         // R10: distance never exceeds the larger operand
         a_r10_absd_bound: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && op == 3'd7) |=>
            ((result[l*LANE_W +: LANE_W] <= $past(src_a[l*LANE_W +: LANE_W])) ||
             (result[l*LANE_W +: LANE_W] <= $past(src_b[l*LANE_W +: LANE_W]))));
      end
   endgenerate
endmodule

bind psimd_sat_alu psimd_sat_alu_chk #(.LANE_W(LANE_W), .LANES(LANES)) u_chk (.*);

// File: tb/sim_psimd_sat_alu.sv
module sim_psimd_sat_alu;
   localparam int W = 16;
   localparam int N = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [2:0]    op = '0;
   logic [63:0]   src_a = '0;
   logic [63:0]   src_b = '0;
   logic          out_valid;
   logic [63:0]   result;

   int vectors = 0;
   int fails   = 0;

   always #4 clk = ~clk;

   psimd_sat_alu #(.LANE_W(W), .LANES(N)) u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
      .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result));

   function automatic int lane_ref(input int code, input int a, input int b);
      int sa, sb, r;
      sa = (a >= 32768) ? a - 65536 : a;
      sb = (b >= 32768) ? b - 65536 : b;
      case (code)
         0: r = (a + b) & 16'hFFFF;
         1: r = (a - b) & 16'hFFFF;
         2: r = (a + b > 65535) ? 65535 : a + b;
         3: r = (a > b) ? a - b : 0;
         4: begin r = sa + sb; if (r > 32767) r = 32767; if (r < -32768) r = -32768; r = r & 16'hFFFF; end
         5: begin r = sa - sb; if (r > 32767) r = 32767; if (r < -32768) r = -32768; r = r & 16'hFFFF; end
         6: r = (a > b) ? a : b;
         default: r = (a > b) ? a - b : b - a;
      endcase
      return r;
   endfunction

   function automatic logic [63:0] vec_ref(input int code, input logic [63:0] a, input logic [63:0] b);
      logic [63:0] v;
      for (int k = 0; k < N; k++)
         v[k*W +: W] = 16'(lane_ref(code, int'(a[k*W +: W]), int'(b[k*W +: W])));
      return v;
   endfunction

   function automatic string req_of(input int code);
      case (code)
         0, 1: return "R4";
         2: return "R5";
         3: return "R6";
         4: return "R7";
         5: return "R8";
         6: return "R9";
         default: return "R10";
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic apply(input int code, input logic [63:0] a, input logic [63:0] b, input string req);
      logic [63:0] exp;
      exp      = vec_ref(code, a, b);
      op       = 3'(code);
      src_a    = a;
      src_b    = b;
      in_valid = 1'b1;
      @(negedge clk);
      check({req, " valid"}, {63'd0, out_valid}, 64'd1);
      check(req, result, exp);
   endtask

   logic [63:0] corners [8] = '{64'h0, 64'h1, 64'h7FFE, 64'h7FFF,
                                64'h8000, 64'h8001, 64'hFFFE, 64'hFFFF};

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      logic [63:0] a, b, held;
      logic [31:0] rng;
      rng = 32'h1234_5678;
      src_a = 64'hDEAD_BEEF_0123_4567;
      src_b = 64'h0F0F_F0F0_5555_AAAA;
      in_valid = 1'b1;
      repeat (3) @(negedge clk);
      // R2: reset holds outputs at zero even with in_valid high
      check("R2 valid", {63'd0, out_valid}, 64'd0);
      check("R2 result", result, 64'd0);
      in_valid = 1'b0;
      rst_n = 1'b1;
      @(negedge clk);
      check("R2 after release", result, 64'd0);

      // R6 R9 R10 worked example, word 3 first
      a = {16'd58, 16'd14, 16'd12, 16'd77};
      b = {16'd22, 16'd192, 16'd118, 16'd36};
      apply(3, a, b, "R6");
      check("R6 example", result, {16'd36, 16'd0, 16'd0, 16'd41});
      apply(6, a, b, "R9");
      check("R9 example", result, {16'd58, 16'd192, 16'd118, 16'd77});
      apply(7, a, b, "R10");
      check("R10 example", result, {16'd36, 16'd178, 16'd106, 16'd41});

      // R3: no carry or borrow across word boundaries
      apply(0, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_0001, "R3");
      check("R3 carry", result, 64'h0);
      apply(1, 64'h0001_0000_0000_0000, 64'h0000_0001_0000_0001, "R3");
      check("R3 borrow", result, 64'h0001_FFFF_0000_FFFF);

      // R11: idle edge keeps result and drops valid
      held = result;
      src_a = ~src_a;
      src_b = 64'h1111_2222_3333_4444;
      op = 3'd2;
      in_valid = 1'b0;
      @(negedge clk);
      check("R11 valid", {63'd0, out_valid}, 64'd0);
      check("R11 result", result, held);

      // corner sweep across all codes, operands rotated among words
      for (int c = 0; c < 8; c++)
         for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++) begin
               for (int k = 0; k < N; k++) begin
                  a[k*W +: W] = corners[(i + k) % 8][15:0];
                  b[k*W +: W] = corners[(j + 3*k) % 8][15:0];
               end
               apply(c, a, b, req_of(c));
            end

      // R1: back-to-back pseudo-random vectors, one result per cycle
      for (int n = 0; n < 1600; n++) begin
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
         a[31:0] = rng;
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
         a[63:32] = rng;
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
         b[31:0] = rng;
         rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
         b[63:32] = rng;
         apply(n % 8, a, b, (n % 16 == 0) ? "R1" : req_of(n % 8));
         if (n % 97 == 0) begin
            held = result;
            in_valid = 1'b0;
            op = 3'(n % 8);
            src_a = b;
            @(negedge clk);
            check("R11 idle", result, held);
            check("R11 valid", {63'd0, out_valid}, 64'd0);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule